// File: doc/BRIEF.md
# Hot-Plug and Power-Management Event Status Register

This block is a single 32-bit status word inside a root port's configuration space. It watches three event sources for rising edges: a link-active change, a presence-detect change and a root PME status bit. When the enable that matches a source is set, the edge latches a sticky flag. Two further sticky flags record that an interrupt has been routed to the SCI path, one from the power-management logic and one from the hot-plug controller. A combined SMI request is raised while any of the three edge-driven flags is held.

Software reads the word through a plain configuration read/write port. It clears a flag by writing one to that bit position, and only the byte lanes whose enables are set take part. Reserved positions have no storage. A set event always wins over a clear that lands on the same bit in the same cycle, so no event is lost.

Top module: `evt_status_reg`

## Requirements
- R1: While reset is asserted and on the first read after it, every bit reads 0 and `smi_req` is 0.
- R2: Bit 4 becomes 1 one clock after the edge at which `link_chg_src` is 1 and was 0 at the previous edge, provided `hp_smi_en` is 1 at that edge. A level held high, or a rise with `hp_smi_en` at 0, does not set it.
- R3: Bit 1 follows the rule of R2 for `pres_chg_src`, gated by `hp_smi_en`.
- R4: Bit 0 follows the rule of R2 for `pme_src`, gated by `pm_smi_en`.
- R5: Bit 31 becomes 1 one clock after any edge at which `pm_sci_req` is 1, and bit 30 likewise for `hp_sci_req`. Both stay 1 after the request drops.
- R6: A write at the register's address clears each implemented bit whose write-data bit is 1 and whose byte lane enable (`cfg_be[k]` covers bits 8k+7..8k) is 1. Write-data 0 or a disabled lane leaves the bit unchanged.
- R7: Bits 29..5, 3 and 2 always read 0, and writes to them have no effect on any bit.
- R8: `smi_req` is 1 exactly while any of bits 4, 1 or 0 is 1, and stays 1 until software has cleared all of them.
- R9: When a set condition and a clearing write hit the same bit in the same cycle, the bit is 1 afterwards.
- R10: The register answers at byte address `REG_OFFSET` (default DCh); address bits 1..0 are ignored. `cfg_rdata` shows the status word while `cfg_rd_en` is 1 and the address matches, and 0 otherwise; writes at any other address change nothing.
- R11: The edge history resets to 0, so a source that is already 1 on the first clock after reset counts as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data, a 1 clears the bit |
| cfg_rdata | output | 32 | Read data, combinational |
| link_chg_src | input | 1 | Link-active-changed source status |
| pres_chg_src | input | 1 | Presence-detect-changed source status |
| pme_src | input | 1 | Root PME source status |
| hp_smi_en | input | 1 | Enables hot-plug SMI flags (bits 4 and 1) |
| pm_smi_en | input | 1 | Enables power-management SMI flag (bit 0) |
| pm_sci_req | input | 1 | Power-management interrupt routed to SCI |
| hp_sci_req | input | 1 | Hot-plug interrupt routed to SCI |
| smi_req | output | 1 | Combined SMI request |

## Verification
Every flag is visible on `cfg_rdata` in the cycle after its setting edge, since the bench keeps a read open at the register address, so a wrong sticky cell, a lost clear or a missed set shows within one clock. A corrupted edge history shows as a flag that sets on a held level or misses a real rise, again one clock later. A fault in the SMI combination shows on `smi_req` in the same cycle that the flags change, and the behavioural model compares both outputs after every clock.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;

  localparam int REG_W = 32;

  // bit positions decoded by software
  localparam int POS_PME_SMI  = 0;
  localparam int POS_PRES_SMI = 1;
  localparam int POS_LINK_SMI = 4;
  localparam int POS_HP_SCI   = 30;
  localparam int POS_PM_SCI   = 31;

  // edge source indices
  localparam int SRC_LINK = 0;
  localparam int SRC_PRES = 1;
  localparam int SRC_PME  = 2;
  localparam int NUM_SRC  = 3;

  localparam logic [REG_W-1:0] ONE_W = {{(REG_W-1){1'b0}}, 1'b1};

  localparam logic [REG_W-1:0] SMI_MASK =
      (ONE_W << POS_PME_SMI) | (ONE_W << POS_PRES_SMI) | (ONE_W << POS_LINK_SMI);

  localparam logic [REG_W-1:0] SCI_MASK =
      (ONE_W << POS_HP_SCI) | (ONE_W << POS_PM_SCI);

  localparam logic [REG_W-1:0] IMPL_MASK = SMI_MASK | SCI_MASK;

endpackage

// File: rtl/evt_edge_bank.sv
module evt_edge_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= src_i;
  end

  assign rise_o = src_i & ~hist_q;

endmodule

// File: rtl/evt_sticky_cell.sv
module evt_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // set has priority so an event coinciding with a clear survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/evt_cfg_port.sv
module evt_cfg_port #(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'hDC
) (
  input  logic                  rd_en_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     status_i,
  output logic [DATA_W-1:0]     clr_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int NB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ALIGN = ~{{(ADDR_W-2){1'b0}}, 2'b11};

  logic              hit;
  logic [DATA_W-1:0] lane_mask;

  assign hit = ((addr_i & ALIGN) == (OFFSET & ALIGN));

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  assign clr_o   = (wr_en_i && hit) ? (wdata_i & lane_mask) : '0;
  assign rdata_o = (rd_en_i && hit) ? status_i : '0;

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_stat_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hDC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              link_chg_src,
  input  logic              pres_chg_src,
  input  logic              pme_src,
  input  logic              hp_smi_en,
  input  logic              pm_smi_en,
  input  logic              pm_sci_req,
  input  logic              hp_sci_req,
  output logic              smi_req
);

  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic [REG_W-1:0]   set_vec;
  logic [REG_W-1:0]   clr_vec;
  logic [REG_W-1:0]   status_q;
  logic               unused_clr_bits;

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_LINK] = link_chg_src;
    src_vec[SRC_PRES] = pres_chg_src;
    src_vec[SRC_PME]  = pme_src;
  end

  evt_edge_bank #(.N(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_vec),
    .rise_o (rise_vec)
  );

  always_comb begin
    set_vec               = '0;
    set_vec[POS_LINK_SMI] = rise_vec[SRC_LINK] & hp_smi_en;
    set_vec[POS_PRES_SMI] = rise_vec[SRC_PRES] & hp_smi_en;
    set_vec[POS_PME_SMI]  = rise_vec[SRC_PME]  & pm_smi_en;
    set_vec[POS_PM_SCI]   = pm_sci_req;
    set_vec[POS_HP_SCI]   = hp_sci_req;
  end

  evt_cfg_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (REG_W),
    .OFFSET (REG_OFFSET)
  ) u_port (
    .rd_en_i  (cfg_rd_en),
    .wr_en_i  (cfg_wr_en),
    .addr_i   (cfg_addr),
    .be_i     (cfg_be),
    .wdata_i  (cfg_wdata),
    .status_i (status_q),
    .clr_o    (clr_vec),
    .rdata_o  (cfg_rdata)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_cell
      evt_sticky_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (status_q[i])
      );
    end else begin : g_rsvd
      assign status_q[i] = 1'b0;
    end
  end

  assign unused_clr_bits = ^((clr_vec | set_vec) & ~IMPL_MASK);

  assign smi_req = |(status_q & SMI_MASK);

endmodule

// File: rtl/evt_status_reg_chk.sv
module evt_status_reg_chk
  import evt_stat_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'hDC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              be0,
  input logic              wd0,
  input logic [31:0]       rdata,
  input logic              link_src,
  input logic              pres_src,
  input logic              pme_src,
  input logic              hp_en,
  input logic              pm_en,
  input logic              pm_sci,
  input logic              hp_sci,
  input logic              smi,
  input logic              st_link,
  input logic              st_pres,
  input logic              st_pme,
  input logic              st_pm_sci,
  input logic              st_hp_sci
);

  localparam logic [ADDR_W-1:0] ALIGN = ~{{(ADDR_W-2){1'b0}}, 2'b11};

  logic hit;
  assign hit = ((addr & ALIGN) == (OFFSET & ALIGN));

  p_link_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_src && !$past(link_src) && hp_en) |=> st_link);

  p_link_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_link) |-> $past(link_src && hp_en));

  p_pres_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_src && !$past(pres_src) && hp_en) |=> st_pres);

  p_pres_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pres) |-> $past(pres_src && hp_en));

  p_pme_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_src && !$past(pme_src) && pm_en) |=> st_pme);

  p_pme_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pme) |-> $past(pme_src && pm_en));

  p_pm_sci_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_sci |=> st_pm_sci);

  p_hp_sci_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hp_sci |=> st_hp_sci);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pme && wr_en && hit && be0 && wd0 && !(pme_src && !$past(pme_src) && pm_en))
      |=> !st_pme);

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~IMPL_MASK) == '0);

  p_smi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi && !(wr_en && hit)) |=> smi);

endmodule

bind evt_status_reg evt_status_reg_chk #(
  .ADDR_W (ADDR_W),
  .OFFSET (REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (cfg_wr_en),
  .addr      (cfg_addr),
  .be0       (cfg_be[0]),
  .wd0       (cfg_wdata[0]),
  .rdata     (cfg_rdata),
  .link_src  (link_chg_src),
  .pres_src  (pres_chg_src),
  .pme_src   (pme_src),
  .hp_en     (hp_smi_en),
  .pm_en     (pm_smi_en),
  .pm_sci    (pm_sci_req),
  .hp_sci    (hp_sci_req),
  .smi       (smi_req),
  .st_link   (status_q[evt_stat_pkg::POS_LINK_SMI]),
  .st_pres   (status_q[evt_stat_pkg::POS_PRES_SMI]),
  .st_pme    (status_q[evt_stat_pkg::POS_PME_SMI]),
  .st_pm_sci (status_q[evt_stat_pkg::POS_PM_SCI]),
  .st_hp_sci (status_q[evt_stat_pkg::POS_HP_SCI])
);

// File: tb/sim_evt_status_reg.sv
`timescale 1ns/1ps
module sim_evt_status_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rd_en = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [11:0] cfg_addr = 12'hDC;
  logic [3:0]  cfg_be = 4'hF;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        link_chg_src = 1'b0, pres_chg_src = 1'b0, pme_src = 1'b0;
  logic        hp_smi_en = 1'b0, pm_smi_en = 1'b0;
  logic        pm_sci_req = 1'b0, hp_sci_req = 1'b0;
  logic        smi_req;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  evt_status_reg u0 (
    .clk (clk), .rst_n (rst_n),
    .cfg_rd_en (cfg_rd_en), .cfg_wr_en (cfg_wr_en), .cfg_addr (cfg_addr),
    .cfg_be (cfg_be), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
    .link_chg_src (link_chg_src), .pres_chg_src (pres_chg_src), .pme_src (pme_src),
    .hp_smi_en (hp_smi_en), .pm_smi_en (pm_smi_en),
    .pm_sci_req (pm_sci_req), .hp_sci_req (hp_sci_req), .smi_req (smi_req)
  );

  // behavioural reference model
  logic [31:0] m_stat;
  logic [2:0]  m_prev;
  localparam logic [31:0] M_IMPL = 32'hC000_0013;

  function automatic logic m_hit(input logic [11:0] a);
    return (a[11:2] == 10'h037);
  endfunction

  function automatic logic [31:0] m_next();
    logic [31:0] clr = '0;
    logic [31:0] nx;
    if (cfg_wr_en && m_hit(cfg_addr))
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) clr[b*8 +: 8] = cfg_wdata[b*8 +: 8];
    nx = m_stat & ~clr;
    if (link_chg_src && !m_prev[0] && hp_smi_en) nx[4] = 1'b1;
    if (pres_chg_src && !m_prev[1] && hp_smi_en) nx[1] = 1'b1;
    if (pme_src      && !m_prev[2] && pm_smi_en) nx[0] = 1'b1;
    if (pm_sci_req) nx[31] = 1'b1;
    if (hp_sci_req) nx[30] = 1'b1;
    return nx & M_IMPL;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0;
      m_prev <= '0;
    end else begin
      m_stat <= m_next();
      m_prev <= {pme_src, pres_chg_src, link_chg_src};
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic cmp_model();
    logic [31:0] e_rd;
    e_rd = (cfg_rd_en && m_hit(cfg_addr)) ? m_stat : '0;
    chk(cur_req, cfg_rdata, e_rd);
    chk(cur_req, {31'b0, smi_req}, {31'b0, (m_stat[4] | m_stat[1] | m_stat[0])});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    cfg_wr_en = 1'b1; cfg_wdata = d; cfg_be = be;
    tick();
    cfg_wr_en = 1'b0; cfg_wdata = '0; cfg_be = 4'hF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", cfg_rdata, 32'h0);
    chk("R1", {31'b0, smi_req}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1", cfg_rdata, 32'h0);

    // R2 link change
    cur_req = "R2";
    hp_smi_en = 1; link_chg_src = 1; tick();
    chk("R2", cfg_rdata, 32'h10);
    chk("R2", {31'b0, smi_req}, 32'h1);
    wr(32'h10, 4'hF);
    chk("R2", cfg_rdata, 32'h0);
    tick();
    chk("R2", cfg_rdata, 32'h0);            // held level does not re-set
    link_chg_src = 0; tick();
    hp_smi_en = 0; link_chg_src = 1; tick();
    chk("R2", cfg_rdata, 32'h0);            // gated by enable
    link_chg_src = 0; tick();

    // R3 presence change
    cur_req = "R3";
    hp_smi_en = 1; pres_chg_src = 1; tick();
    chk("R3", cfg_rdata, 32'h2);
    pres_chg_src = 0; tick();
    wr(32'h2, 4'hF);
    chk("R3", cfg_rdata, 32'h0);

    // R4 PME
    cur_req = "R4";
    pm_smi_en = 1; pme_src = 1; tick();
    chk("R4", cfg_rdata, 32'h1);
    pme_src = 0; tick();

    // R8 smi held until all cleared
    cur_req = "R8";
    link_chg_src = 1; tick();
    link_chg_src = 0;
    chk("R8", cfg_rdata, 32'h11);
    wr(32'h10, 4'hF);
    chk("R8", cfg_rdata, 32'h1);
    chk("R8", {31'b0, smi_req}, 32'h1);
    wr(32'h1, 4'hF);
    chk("R8", {31'b0, smi_req}, 32'h0);

    // R5 SCI mirrors
    cur_req = "R5";
    pm_sci_req = 1; tick();
    pm_sci_req = 0; tick();
    chk("R5", cfg_rdata, 32'h8000_0000);
    chk("R5", {31'b0, smi_req}, 32'h0);
    hp_sci_req = 1; tick();
    hp_sci_req = 0;
    chk("R5", cfg_rdata, 32'hC000_0000);

    // R6 write-one-to-clear with lanes
    cur_req = "R6";
    wr(32'h0, 4'hF);
    chk("R6", cfg_rdata, 32'hC000_0000);
    wr(32'hC000_0000, 4'b0111);
    chk("R6", cfg_rdata, 32'hC000_0000);
    wr(32'h8000_0000, 4'b1000);
    chk("R6", cfg_rdata, 32'h4000_0000);

    // R10 address decode
    cur_req = "R10";
    cfg_addr = 12'hE0; wr(32'hFFFF_FFFF, 4'hF);
    chk("R10", cfg_rdata, 32'h0);
    cfg_addr = 12'hDE; tick();
    chk("R10", cfg_rdata, 32'h4000_0000);
    cfg_addr = 12'hDC; cfg_rd_en = 0; tick();
    chk("R10", cfg_rdata, 32'h0);
    cfg_rd_en = 1;

    // R7 reserved bits
    cur_req = "R7";
    link_chg_src = 1; tick();
    link_chg_src = 0;
    wr(32'h3FFF_FFEC, 4'hF);
    chk("R7", cfg_rdata, 32'h4000_0010);
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R7", cfg_rdata, 32'h0);

    // R9 set beats clear
    cur_req = "R9";
    pme_src = 1; wr(32'h1, 4'hF);
    chk("R9", cfg_rdata, 32'h1);
    pme_src = 0; tick();
    pme_src = 1; wr(32'h1, 4'hF);
    chk("R9", cfg_rdata, 32'h1);
    pme_src = 0; wr(32'h1, 4'hF);
    chk("R9", cfg_rdata, 32'h0);

    // R11 source high across reset
    cur_req = "R11";
    pme_src = 1; pm_smi_en = 1;
    rst_n = 0; tick(); tick();
    rst_n = 1; tick();
    chk("R11", cfg_rdata, 32'h1);
    pme_src = 0; wr(32'h1, 4'hF);

    // random traffic against the model
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      link_chg_src = 1'($urandom_range(0, 1));
      pres_chg_src = 1'($urandom_range(0, 1));
      pme_src      = 1'($urandom_range(0, 1));
      hp_smi_en    = ($urandom_range(0, 3) != 0);
      pm_smi_en    = ($urandom_range(0, 3) != 0);
      pm_sci_req   = ($urandom_range(0, 7) == 0);
      hp_sci_req   = ($urandom_range(0, 7) == 0);
      cfg_wr_en    = ($urandom_range(0, 2) == 0);
      cfg_wdata    = $urandom;
      cfg_be       = 4'($urandom_range(0, 15));
      cfg_addr     = ($urandom_range(0, 7) == 0) ? 12'hE0 : 12'hDC | 12'($urandom_range(0, 3));
      cfg_rd_en    = ($urandom_range(0, 7) != 0);
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule